// File: doc/BRIEF.md
# Compare-Match Timer (8-bit)

This block is an 8-bit up/down counter with one compare channel, intended for timing and simple waveform generation. The counter moves one step on each cycle in which the timer-clock enable is high and the clock-select field is non-zero. If the select field is zero, or the enable is low, the count holds. The step is up or down, as the control register selects.

The end of the count, TOP, is either the fixed value 0xFF or the active compare value, depending on the mode. The compare value is written into a buffer register. In buffered operation the buffer is copied into the active compare register only when the counter wraps. In unbuffered operation the copy happens on the write itself.

A tick on which the count equals the active compare value sets a sticky match flag and can toggle the waveform pin. A tick that wraps the counter sets a sticky wrap flag. Each flag raises the interrupt line only while its mask bit is set. Software uses a plain single-cycle register port. Writes always complete and reads are combinational, so the port has no back-pressure and no valid/ready pair. Flags are cleared either by writing 1 to them or through the two acknowledge inputs.

Top module: `tmr8_cmp`

## Requirements
- R1: After reset the count, both compare registers, the control, flag and mask registers all read 0, and `wave_out` and `irq` are low.
- R2: The count holds on any cycle where `tick_en` is low or `clk_sel` is zero.
- R3: With control bits 0 (clear-on-compare) and 1 (down) both 0, each tick adds 1. A tick at 0xFF gives 0x00 and sets the wrap flag, which is bit 1 of the flag register (address 4).
- R4: With control bit 0 set and counting up, the tick taken while the count equals the active compare value returns the count to 0x00 and sets the wrap flag.
- R5: With control bit 1 set, each tick subtracts 1. A tick at 0x00 reloads TOP and sets the wrap flag. TOP is 0xFF when control bit 0 is clear and the active compare value when it is set.
- R6: A tick taken while the count equals the active compare value (read at address 3) sets the match flag, which is bit 0 of the flag register.
- R7: A write to the compare buffer (address 2) reaches the active compare value at the wrap tick when control bit 3 is set. When control bit 3 is clear it takes effect immediately. The control register is at address 0.
- R8: Flags are sticky. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. A pulse on `ack_cmp` clears bit 0 and a pulse on `ack_ovf` clears bit 1. A flag being set in the same cycle as a clear stays set.
- R9: `irq` is high exactly when some flag is set whose bit is also set in the mask register (address 5).
- R10: With control bit 2 set, `wave_out` inverts on every match tick. Otherwise it keeps its level.
- R11: A write to the count register (address 1) loads the count. If a tick arrives in the same cycle, the write wins and the tick is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for writes and reads |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| tick_en | input | 1 | Qualified timer-clock enable |
| clk_sel | input | 3 | Clock-source select; zero freezes the counter |
| ack_cmp | input | 1 | Interrupt acknowledge, clears the match flag |
| ack_ovf | input | 1 | Interrupt acknowledge, clears the wrap flag |
| wave_out | output | 1 | Waveform output pin |
| irq | output | 1 | Interrupt request |

## Verification
The checker watches several properties on every clock. It confirms that the count holds when no source is selected and steps by one while counting up. It confirms that an up-count wrap lands on zero and that every match or wrap tick leaves its flag set. It also confirms that the active compare value moves only on a wrap or an unbuffered write, that `irq` stays low under a zero mask, and that the pin changes only after a toggle-enabled match. Some behaviour appears only in the bench's scenarios: the exact reload value of a down-count wrap, a buffered value appearing at the wrap, clearing by write-one versus write-zero, set taking priority over acknowledge, and a count write winning over a simultaneous tick.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

  localparam int REG_AW = 3;
  localparam int NFLG   = 2;
  localparam int FLG_CMP = 0;
  localparam int FLG_OVF = 1;

  typedef enum logic [REG_AW-1:0] {
    A_CTRL = 3'd0,
    A_CNT  = 3'd1,
    A_CMPB = 3'd2,
    A_CMPA = 3'd3,
    A_FLG  = 3'd4,
    A_MSK  = 3'd5
  } reg_addr_e;

  // packed MSB first: buf_en is bit 3, clr_on_cmp is bit 0
  typedef struct packed {
    logic buf_en;
    logic toggle_en;
    logic down;
    logic clr_on_cmp;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/tmr8_regs.sv
module tmr8_regs
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      cnt,
  input  logic              hit,
  input  logic              wrap,
  input  logic              ack_cmp,
  input  logic              ack_ovf,
  output ctrl_t             ctrl,
  output logic [W-1:0]      cmp_act,
  output logic [NFLG-1:0]   flags,
  output logic [NFLG-1:0]   mask,
  output logic [W-1:0]      rdata,
  output logic              cnt_wr,
  output logic [W-1:0]      cnt_wdata
);

  logic [W-1:0]    cmp_buf;
  logic            wr_ctrl, wr_cmp, wr_flg, wr_msk;
  logic [NFLG-1:0] set_v, clr_v;

  assign wr_ctrl   = we && (addr == A_CTRL);
  assign wr_cmp    = we && (addr == A_CMPB);
  assign wr_flg    = we && (addr == A_FLG);
  assign wr_msk    = we && (addr == A_MSK);
  assign cnt_wr    = we && (addr == A_CNT);
  assign cnt_wdata = wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      mask <= '0;
    end else begin
      if (wr_ctrl) ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
      if (wr_msk)  mask <= wdata[NFLG-1:0];
    end
  end

  // compare buffer and the active copy used by the counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_buf <= '0;
      cmp_act <= '0;
    end else begin
      if (wr_cmp) cmp_buf <= wdata;
      if (wr_cmp && !ctrl.buf_en)      cmp_act <= wdata;
      else if (wrap && ctrl.buf_en)    cmp_act <= cmp_buf;
    end
  end

  assign set_v = {wrap, hit};
  assign clr_v = ({NFLG{wr_flg}} & wdata[NFLG-1:0]) | {ack_ovf, ack_cmp};

  for (genvar i = 0; i < NFLG; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flags[i] <= 1'b0;
      else if (set_v[i]) flags[i] <= 1'b1;
      else if (clr_v[i]) flags[i] <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:  rdata = {{(W-CTRL_W){1'b0}}, ctrl};
      A_CNT:   rdata = cnt;
      A_CMPB:  rdata = cmp_buf;
      A_CMPA:  rdata = cmp_act;
      A_FLG:   rdata = {{(W-NFLG){1'b0}}, flags};
      A_MSK:   rdata = {{(W-NFLG){1'b0}}, mask};
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/tmr8_count.sv
module tmr8_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         clr_on_cmp,
  input  logic         down,
  input  logic [W-1:0] cmp_act,
  output logic [W-1:0] cnt,
  output logic         wrap,
  output logic         hit
);

  localparam logic [W-1:0] MAXV = '1;
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] top_v;
  logic         at_end;

  assign top_v  = clr_on_cmp ? cmp_act : MAXV;
  // an up count above TOP still ends at MAX by natural rollover
  assign at_end = down ? (cnt == ZERO) : ((cnt == top_v) || (cnt == MAXV));
  assign wrap   = adv && at_end;
  assign hit    = adv && (cnt == cmp_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= ZERO;
    else if (load)   cnt <= load_val;
    else if (adv) begin
      if (down) cnt <= at_end ? top_v : cnt - ONE;
      else      cnt <= at_end ? ZERO  : cnt + ONE;
    end
  end

endmodule

// File: rtl/tmr8_wave.sv
module tmr8_wave (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic toggle_en,
  output logic wave
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                wave <= 1'b0;
    else if (hit && toggle_en) wave <= ~wave;
  end

endmodule

// File: rtl/tmr8_cmp.sv
module tmr8_cmp
  import tmr8_pkg::*;
#(
  parameter int W  = 8,
  parameter int SW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  input  logic              tick_en,
  input  logic [SW-1:0]     clk_sel,
  input  logic              ack_cmp,
  input  logic              ack_ovf,
  output logic              wave_out,
  output logic              irq
);

  ctrl_t           ctrl;
  logic [W-1:0]    cnt, cmp_act, cnt_wdata;
  logic [NFLG-1:0] flags, mask;
  logic            cnt_wr, tick_q, adv, wrap, hit;

  assign tick_q = tick_en && (clk_sel != '0);
  assign adv    = tick_q && !cnt_wr;

  tmr8_regs #(.W(W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (reg_we),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .cnt       (cnt),
    .hit       (hit),
    .wrap      (wrap),
    .ack_cmp   (ack_cmp),
    .ack_ovf   (ack_ovf),
    .ctrl      (ctrl),
    .cmp_act   (cmp_act),
    .flags     (flags),
    .mask      (mask),
    .rdata     (reg_rdata),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (cnt_wdata)
  );

  tmr8_count #(.W(W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv        (adv),
    .load       (cnt_wr),
    .load_val   (cnt_wdata),
    .clr_on_cmp (ctrl.clr_on_cmp),
    .down       (ctrl.down),
    .cmp_act    (cmp_act),
    .cnt        (cnt),
    .wrap       (wrap),
    .hit        (hit)
  );

  tmr8_wave u_wave (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit       (hit),
    .toggle_en (ctrl.toggle_en),
    .wave      (wave_out)
  );

  assign irq = |(flags & mask);

endmodule

// File: rtl/tmr8_chk.sv
module tmr8_chk
  import tmr8_pkg::*;
#(
  parameter int W  = 8,
  parameter int SW = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_addr,
  input logic [SW-1:0]     clk_sel,
  input ctrl_t             ctrl,
  input logic [W-1:0]      cnt,
  input logic [W-1:0]      cmp_act,
  input logic [NFLG-1:0]   flags,
  input logic [NFLG-1:0]   mask,
  input logic              cnt_wr,
  input logic              adv,
  input logic              wrap,
  input logic              hit,
  input logic              irq,
  input logic              wave_out
);

  localparam logic [W-1:0] ONE = W'(1);

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == '0 && !cnt_wr) |=> $stable(cnt)); // R2

  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !ctrl.down && !wrap) |=> (cnt == $past(cnt) + ONE)); // R3

  AST_UP_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !ctrl.down) |=> (cnt == '0)); // R4

  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flags[FLG_OVF]); // R3

  AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flags[FLG_CMP]); // R6

  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap && !(reg_we && reg_addr == A_CMPB)) |=> $stable(cmp_act)); // R7

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq); // R9

  AST_WAVE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wave_out) |-> $past(hit && ctrl.toggle_en)); // R10

endmodule

bind tmr8_cmp tmr8_chk #(.W(W), .SW(SW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .clk_sel  (clk_sel),
  .ctrl     (ctrl),
  .cnt      (cnt),
  .cmp_act  (cmp_act),
  .flags    (flags),
  .mask     (mask),
  .cnt_wr   (cnt_wr),
  .adv      (adv),
  .wrap     (wrap),
  .hit      (hit),
  .irq      (irq),
  .wave_out (wave_out)
);

// File: tb/tb_tmr8_cmp.sv
module tb_tmr8_cmp;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 27;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       tick_en = 1'b0;
  logic [2:0] clk_sel = '0;
  logic       ack_cmp = 1'b0;
  logic       ack_ovf = 1'b0;
  logic       wave_out, irq;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr8_cmp dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_en(tick_en),
    .clk_sel(clk_sel), .ack_cmp(ack_cmp), .ack_ovf(ack_ovf),
    .wave_out(wave_out), .irq(irq)
  );

  // {req, we, addr, wdata, tick, sel, check_addr, expected}
  localparam logic [30:0] VEC [NV] = '{
    {4'd7,  1'b1, 3'd0, 8'h08, 1'b0, 3'd1, 3'd0, 8'h08}, // R7 buffered, mode 0 up
    {4'd7,  1'b1, 3'd2, 8'h05, 1'b0, 3'd1, 3'd3, 8'h00}, // R7 active not yet loaded
    {4'd11, 1'b1, 3'd1, 8'hFD, 1'b0, 3'd1, 3'd1, 8'hFD}, // R11 count load
    {4'd3,  1'b0, 3'd0, 8'h00, 1'b1, 3'd1, 3'd1, 8'hFE}, // R3 step up
    {4'd2,  1'b0, 3'd0, 8'h00, 1'b1, 3'd0, 3'd1, 8'hFE}, // R2 select zero
    {4'd2,  1'b0, 3'd0, 8'h00, 1'b0, 3'd1, 3'd1, 8'hFE}, // R2 enable low
    {4'd3,  1'b0, 3'd0, 8'h00, 1'b1, 3'd1, 3'd1, 8'hFF}, // R3
    {4'd3,  1'b0, 3'd0, 8'h00, 1'b1, 3'd1, 3'd4, 8'h02}, // R3 wrap flag
    {4'd7,  1'b0, 3'd0, 8'h00, 1'b0, 3'd1, 3'd3, 8'h05}, // R7 loaded at wrap
    {4'd8,  1'b1, 3'd4, 8'h00, 1'b0, 3'd1, 3'd4, 8'h02}, // R8 write 0 keeps
    {4'd8,  1'b1, 3'd4, 8'h02, 1'b0, 3'd1, 3'd4, 8'h00}, // R8 write 1 clears
    {4'd4,  1'b1, 3'd0, 8'h05, 1'b0, 3'd1, 3'd1, 8'h00}, // R4 clear-on-compare, toggle
    {4'd7,  1'b1, 3'd2, 8'h03, 1'b0, 3'd1, 3'd3, 8'h03}, // R7 unbuffered immediate
    {4'd4,  1'b0, 3'd0, 8'h00, 1'b1, 3'd2, 3'd1, 8'h01}, // R4
    {4'd4,  1'b0, 3'd0, 8'h00, 1'b1, 3'd2, 3'd1, 8'h02}, // R4
    {4'd4,  1'b0, 3'd0, 8'h00, 1'b1, 3'd2, 3'd1, 8'h03}, // R4
    {4'd6,  1'b0, 3'd0, 8'h00, 1'b1, 3'd2, 3'd4, 8'h03}, // R6 match and wrap
    {4'd4,  1'b0, 3'd0, 8'h00, 1'b0, 3'd2, 3'd1, 8'h00}, // R4 cleared to bottom
    {4'd5,  1'b1, 3'd0, 8'h07, 1'b0, 3'd1, 3'd0, 8'h07}, // R5 down, clear-on-compare
    {4'd8,  1'b1, 3'd4, 8'h03, 1'b0, 3'd1, 3'd4, 8'h00}, // R8 clear both
    {4'd5,  1'b0, 3'd0, 8'h00, 1'b1, 3'd1, 3'd1, 8'h03}, // R5 reload compare value
    {4'd6,  1'b0, 3'd0, 8'h00, 1'b1, 3'd1, 3'd4, 8'h03}, // R6 match on down count
    {4'd5,  1'b1, 3'd0, 8'h02, 1'b0, 3'd1, 3'd0, 8'h02}, // R5 mode 0 down
    {4'd11, 1'b1, 3'd1, 8'h00, 1'b0, 3'd1, 3'd1, 8'h00}, // R11
    {4'd5,  1'b0, 3'd0, 8'h00, 1'b1, 3'd1, 3'd1, 8'hFF}, // R5 reload 0xFF
    {4'd11, 1'b1, 3'd1, 8'h10, 1'b1, 3'd1, 3'd1, 8'h10}, // R11 write beats tick
    {4'd2,  1'b0, 3'd0, 8'h00, 1'b1, 3'd4, 3'd1, 8'h0F}  // R2 other select value
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [2:0] a, input logic [7:0] wd,
                      input logic tk, input logic [2:0] sel,
                      input logic ac, input logic ao);
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = wd;
    tick_en = tk; clk_sel = sel; ack_cmp = ac; ack_ovf = ao;
    @(posedge clk);
    #1;
    reg_we = 1'b0; tick_en = 1'b0; ack_cmp = 1'b0; ack_ovf = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [2:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      reg_addr = 3'(a);
      #1;
      check("R1 register", reg_rdata, 8'h00);
    end
    check("R1 wave_out", {7'd0, wave_out}, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][26], VEC[i][25:23], VEC[i][22:15], VEC[i][14], VEC[i][13:11], 1'b0, 1'b0);
      rd_check($sformatf("R%0d vector %0d", VEC[i][30:27], i), VEC[i][10:8], VEC[i][7:0]);
    end

    // R9: flags 0x03 pending, mask still zero
    check("R9 masked irq", {7'd0, irq}, 8'h00);
    check("R10 wave after table", {7'd0, wave_out}, 8'h00);

    // R10 / R6: toggle on match in mode 0 up, unbuffered compare 0x20
    step(1'b1, 3'd0, 8'h04, 1'b0, 3'd1, 1'b0, 1'b0);
    step(1'b1, 3'd2, 8'h20, 1'b0, 3'd1, 1'b0, 1'b0);
    step(1'b1, 3'd4, 8'h03, 1'b0, 3'd1, 1'b0, 1'b0);
    step(1'b1, 3'd1, 8'h1F, 1'b0, 3'd1, 1'b0, 1'b0);
    step(1'b0, 3'd0, 8'h00, 1'b1, 3'd1, 1'b0, 1'b0);
    check("R10 no toggle before match", {7'd0, wave_out}, 8'h00);
    step(1'b0, 3'd0, 8'h00, 1'b1, 3'd1, 1'b0, 1'b0);
    check("R10 toggle on match", {7'd0, wave_out}, 8'h01);
    rd_check("R6 match flag", 3'd4, 8'h01);

    // R9 unmask match flag
    step(1'b1, 3'd5, 8'h01, 1'b0, 3'd1, 1'b0, 1'b0);
    check("R9 irq raised", {7'd0, irq}, 8'h01);

    // R8 acknowledge clears
    step(1'b0, 3'd0, 8'h00, 1'b0, 3'd1, 1'b1, 1'b0);
    rd_check("R8 ack clears", 3'd4, 8'h00);
    check("R9 irq dropped", {7'd0, irq}, 8'h00);

    // R8 set beats acknowledge in the same cycle
    step(1'b1, 3'd1, 8'h20, 1'b0, 3'd1, 1'b0, 1'b0);
    step(1'b0, 3'd0, 8'h00, 1'b1, 3'd1, 1'b1, 1'b0);
    rd_check("R8 set priority", 3'd4, 8'h01);
    check("R10 toggle back", {7'd0, wave_out}, 8'h00);
    check("R9 irq again", {7'd0, irq}, 8'h01);

    finish_run();
  end

endmodule